// File: doc/BRIEF.md
# Cascaded Display Loader

This block sits on the host side of a chain of serial LED dot-matrix driver chips. It produces the display reset, register-select, active-low enable, serial clock and serial data lines. Every setup, hold and clock phase on these lines is a programmable number of system clock cycles. After the block leaves reset, it brings the chain up without help from the host. It pulses the display reset, clears the whole dot chain, and then writes the brightness control word with the wake bit set.

Once the bring-up is complete, the host can request one of two writes. A frame write sends a full picture of eight 5x8 character cells across two chips. A control write sends a control byte to every chip in the chain. Frame bits are streamed in the order the chips expect, with the unused bottom row of each column forced to zero. Control writes are repeated once per chip. The exception is when a control word 1 write has put the chain into simultaneous mode; then a single copy reaches all chips. The block drives `busy` while a transaction is in progress and pulses `done` when each one finishes.

Top module: `disp_chain_loader`

## Requirements
- R1: While `rst` is high, `disp_rst_n` is low, `ce_n` high, `sclk` low, `busy` high and `done` low. After `rst` falls, `disp_rst_n` stays low for exactly RST_LEN clock cycles.
- R2: The first transaction after reset is a dot write: `rs` is low and there are NCHIP*CELLS*COLS*ROWS (320) rising `sclk` edges, each carrying 0 on `din`.
- R3: The second transaction is a control write: `rs` is high and NCHIP copies of the byte {0, 1, bright_in[5:0]} are sent (bit 7 = 0 selects word 0, bit 6 = 1 wakes the chip). It ends with a one-cycle `done` and `busy` low.
- R4: In a frame write (`op_ctrl` = 0), rising edge j (0-based) carries frame_in[j], where j = (cell*COLS + col)*ROWS + row. Cell 0 is the leftmost character, col 0 is the left column of a cell, and row 0 is the bottom row. Every row-0 bit is sent as 0.
- R5: In a control write (`op_ctrl` = 1, `rs` high), each byte is sent most significant bit first. Without simultaneous mode, the byte is repeated NCHIP times (8*NCHIP edges).
- R6: When ctrl_in[7] = 1 (control word 1), bits 6..2 are always sent as 0. Bits 7, 1 and 0 are passed through unchanged.
- R7: After a control write of word 1 with bit 0 = 1 completes, later control writes send a single 8-edge copy. A control word 1 write with bit 0 = 0 (sent as one copy) restores NCHIP copies.
- R8: `rs` is stable for at least RS_SETUP cycles before `ce_n` falls, and it does not change while `ce_n` is low.
- R9: `ce_n` falls only while `sclk` is low. `ce_n` rises while `sclk` is high, and `sclk` then falls with `ce_n` high to latch the data. There are no rising `sclk` edges while `ce_n` is high.
- R10: `sclk` stays high for at least CLK_HI cycles. While `ce_n` is low, `sclk` stays low for at least CLK_LO cycles before each rise.
- R11: A `start` that arrives while `busy` is high is ignored and causes no extra transaction. `done` is high for exactly one cycle per transaction, and `busy` is low in that cycle.
- R12: `din` does not change while `sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a transaction (accepted only when idle) |
| op_ctrl | input | 1 | 0 = frame write, 1 = control write |
| frame_in | input | NCHIP*CELLS*COLS*ROWS | Frame bits, indexed as in R4 |
| ctrl_in | input | 8 | Control byte; bit 7 selects the control word |
| bright_in | input | 6 | Brightness bits used by the power-up control write |
| disp_rst_n | output | 1 | Active-low display reset |
| rs | output | 1 | Register select: 0 dot data, 1 control |
| ce_n | output | 1 | Active-low chip enable |
| sclk | output | 1 | Serial clock to the chain |
| din | output | 1 | Serial data to the chain |
| busy | output | 1 | A transaction or the bring-up sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of each transaction |

## Verification
The bench uses the default two-chip, 320-bit chain, so both the full frame length and the two-copy control repetition are exercised. It uses deliberately unequal short timing counts: RST_LEN 5, RS_SETUP 2, RS_HOLD 3, CE_SETUP 3, CLK_HI 2 and CLK_LO 3. With these values, an off-by-one in any single phase counter shows up as a width violation or a wrong reset length. The short counts also keep a full frame to about 1600 cycles, which leaves room for several random frames, a toggle into and out of simultaneous mode, and a start pulse dropped in the middle of a write.

// File: rtl/dl_pkg.sv
package dl_pkg;

    typedef enum logic [2:0] {
        ST_RST,
        ST_IDLE,
        ST_RSSU,
        ST_CESU,
        ST_LO,
        ST_HI,
        ST_CEHOLD,
        ST_RSHOLD
    } dl_state_e;

    typedef enum logic [1:0] {
        PH_INIT_DOT,
        PH_INIT_CW,
        PH_USER
    } dl_phase_e;

    typedef struct packed {
        logic rst_n;
        logic ce_n;
        logic sclk;
    } dl_pins_t;

    localparam dl_pins_t PINS_RESET = '{rst_n: 1'b0, ce_n: 1'b1, sclk: 1'b0};

    // Word 1 keeps only its select bit and its two low configuration bits.
    function automatic logic [7:0] ctrl_clean(input logic [7:0] w);
        return w[7] ? {1'b1, 5'b00000, w[1:0]} : w;
    endfunction

    // Word 0 with the wake bit set and the requested brightness.
    function automatic logic [7:0] cw0_word(input logic [5:0] b);
        return {1'b0, 1'b1, b};
    endfunction

endpackage

// File: rtl/dl_timer.sv
module dl_timer #(
    parameter int W    = 16,
    parameter int INIT = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(INIT);
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/dl_stream.sv
module dl_stream #(
    parameter int FRAME_BITS = 320,
    parameter int ROWS       = 8,
    parameter int IDXW       = 9
) (
    input  logic [FRAME_BITS-1:0] frame_i,
    input  logic [7:0]            byte_i,
    input  logic                  is_ctrl,
    input  logic [IDXW-1:0]       idx,
    output logic                  bit_o
);
    localparam int NCOLS = FRAME_BITS / ROWS;

    logic [FRAME_BITS-1:0] shown;

    // The bottom row of every column has no LED: send it as zero.
    for (genvar g = 0; g < NCOLS; g++) begin : g_col
        assign shown[g*ROWS +: ROWS] = frame_i[g*ROWS +: ROWS] & {{(ROWS-1){1'b1}}, 1'b0};
    end

    assign bit_o = is_ctrl ? byte_i[3'd7 - idx[2:0]] : shown[idx];
endmodule

// File: rtl/disp_chain_loader.sv
module disp_chain_loader
    import dl_pkg::*;
#(
    parameter int NCHIP    = 2,
    parameter int CELLS    = 4,
    parameter int COLS     = 5,
    parameter int ROWS     = 8,
    parameter int RST_LEN  = 8,
    parameter int RS_SETUP = 2,
    parameter int RS_HOLD  = 2,
    parameter int CE_SETUP = 3,
    parameter int CLK_HI   = 4,
    parameter int CLK_LO   = 4
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  logic                               op_ctrl,
    input  logic [NCHIP*CELLS*COLS*ROWS-1:0]   frame_in,
    input  logic [7:0]                         ctrl_in,
    input  logic [5:0]                         bright_in,
    output logic                               disp_rst_n,
    output logic                               rs,
    output logic                               ce_n,
    output logic                               sclk,
    output logic                               din,
    output logic                               busy,
    output logic                               done
);
    localparam int FRAME_BITS = NCHIP * CELLS * COLS * ROWS;
    localparam int IDXW       = $clog2(FRAME_BITS + 1);
    localparam int TW         = 16;

    dl_state_e             st, st_n;
    dl_phase_e             ph;
    dl_pins_t              pins_q, pins_n;
    logic [IDXW-1:0]       idx, last_idx, ctrl_last;
    logic [FRAME_BITS-1:0] frame_q;
    logic [7:0]            byte_q;
    logic                  rs_q, is_ctrl_q, sim_q, done_q;
    logic                  go_init_dot, go_init_cw, go_user, finish;
    logic                  tmr_load, tmr_zero;
    logic [TW-1:0]         tmr_val;

    assign ctrl_last = sim_q ? IDXW'(7) : IDXW'(NCHIP*8 - 1);

    always_comb begin
        st_n        = st;
        go_init_dot = 1'b0;
        go_init_cw  = 1'b0;
        go_user     = 1'b0;
        finish      = 1'b0;
        unique case (st)
            ST_RST:    if (tmr_zero) begin go_init_dot = 1'b1; st_n = ST_RSSU; end
            ST_IDLE:   if (start) begin go_user = 1'b1; st_n = ST_RSSU; end
            ST_RSSU:   if (tmr_zero) st_n = ST_CESU;
            ST_CESU:   if (tmr_zero) st_n = ST_LO;
            ST_LO:     if (tmr_zero) st_n = ST_HI;
            ST_HI:     if (tmr_zero) st_n = (idx == last_idx) ? ST_CEHOLD : ST_LO;
            ST_CEHOLD: if (tmr_zero) st_n = ST_RSHOLD;
            ST_RSHOLD: if (tmr_zero) begin
                if (ph == PH_INIT_DOT) begin
                    go_init_cw = 1'b1;
                    st_n       = ST_RSSU;
                end else begin
                    finish = 1'b1;
                    st_n   = ST_IDLE;
                end
            end
            default:   st_n = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (st_n)
            ST_RSSU:   tmr_val = TW'(RS_SETUP - 1);
            ST_CESU:   tmr_val = TW'(CE_SETUP - 1);
            ST_LO:     tmr_val = TW'(CLK_LO - 1);
            ST_HI:     tmr_val = TW'(CLK_HI - 1);
            ST_CEHOLD: tmr_val = TW'(CLK_HI - 1);
            ST_RSHOLD: tmr_val = TW'(RS_HOLD - 1);
            default:   tmr_val = '0;
        endcase
        tmr_load     = (st_n != st);
        pins_n.rst_n = (st_n != ST_RST);
        pins_n.ce_n  = !(st_n inside {ST_CESU, ST_LO, ST_HI});
        pins_n.sclk  = (st_n inside {ST_HI, ST_CEHOLD});
    end

    dl_timer #(.W(TW), .INIT(RST_LEN - 1)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .val  (tmr_val),
        .zero (tmr_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_RST;
            ph        <= PH_INIT_DOT;
            pins_q    <= PINS_RESET;
            rs_q      <= 1'b0;
            is_ctrl_q <= 1'b0;
            sim_q     <= 1'b0;
            done_q    <= 1'b0;
            idx       <= '0;
            last_idx  <= '0;
            frame_q   <= '0;
            byte_q    <= '0;
        end else begin
            st     <= st_n;
            pins_q <= pins_n;
            done_q <= finish;
            if (st == ST_HI && st_n == ST_LO)
                idx <= idx + IDXW'(1);
            if (go_init_dot) begin
                ph        <= PH_INIT_DOT;
                rs_q      <= 1'b0;
                is_ctrl_q <= 1'b0;
                sim_q     <= 1'b0;
                frame_q   <= '0;
                idx       <= '0;
                last_idx  <= IDXW'(FRAME_BITS - 1);
            end
            if (go_init_cw) begin
                ph        <= PH_INIT_CW;
                rs_q      <= 1'b1;
                is_ctrl_q <= 1'b1;
                byte_q    <= cw0_word(bright_in);
                idx       <= '0;
                last_idx  <= ctrl_last;
            end
            if (go_user) begin
                ph        <= PH_USER;
                rs_q      <= op_ctrl;
                is_ctrl_q <= op_ctrl;
                idx       <= '0;
                if (op_ctrl) begin
                    byte_q   <= ctrl_clean(ctrl_in);
                    last_idx <= ctrl_last;
                end else begin
                    frame_q  <= frame_in;
                    last_idx <= IDXW'(FRAME_BITS - 1);
                end
            end
            if (finish && is_ctrl_q && byte_q[7])
                sim_q <= byte_q[0];
        end
    end

    dl_stream #(.FRAME_BITS(FRAME_BITS), .ROWS(ROWS), .IDXW(IDXW)) u_stream (
        .frame_i (frame_q),
        .byte_i  (byte_q),
        .is_ctrl (is_ctrl_q),
        .idx     (idx),
        .bit_o   (din)
    );

    assign disp_rst_n = pins_q.rst_n;
    assign ce_n       = pins_q.ce_n;
    assign sclk       = pins_q.sclk;
    assign rs         = rs_q;
    assign busy       = (st != ST_IDLE);
    assign done       = done_q;
endmodule

// File: rtl/dl_checker.sv
module dl_checker #(
    parameter int CLK_HI = 4,
    parameter int CLK_LO = 4
) (
    input logic clk,
    input logic rst,
    input logic disp_rst_n,
    input logic rs,
    input logic ce_n,
    input logic sclk,
    input logic din,
    input logic busy,
    input logic done
);
    logic [15:0] hi_cnt, lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= sclk ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1) : 16'd0;
            lo_cnt <= (!sclk && !ce_n) ? ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1) : 16'd0;
        end
    end

    // R1
    disp_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !disp_rst_n |-> (ce_n && busy));

    // R8
    rs_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !ce_n |-> $stable(rs));

    // R9
    ce_fall_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ce_n) |-> !sclk);

    // R9
    ce_rise_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ce_n) |-> sclk);

    // R9
    no_edge_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n && $past(ce_n)) |-> !$rose(sclk));

    // R10
    clk_high_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (hi_cnt >= 16'(CLK_HI)));

    // R10
    clk_low_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> (lo_cnt >= 16'(CLK_LO)));

    // R12
    din_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(din));

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind disp_chain_loader dl_checker #(.CLK_HI(CLK_HI), .CLK_LO(CLK_LO)) u_dl_checker (
    .clk        (clk),
    .rst        (rst),
    .disp_rst_n (disp_rst_n),
    .rs         (rs),
    .ce_n       (ce_n),
    .sclk       (sclk),
    .din        (din),
    .busy       (busy),
    .done       (done)
);

// File: tb/test_disp_chain_loader.sv
module test_disp_chain_loader;
    localparam int NCHIP = 2, CELLS = 4, COLS = 5, ROWS = 8;
    localparam int FB = NCHIP * CELLS * COLS * ROWS;
    localparam int RST_LEN = 5, RS_SETUP = 2, RS_HOLD = 3, CE_SETUP = 3, CLK_HI = 2, CLK_LO = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic op_ctrl = 1'b0;
    logic [FB-1:0] frame_in = '0;
    logic [7:0] ctrl_in = '0;
    logic [5:0] bright_in = 6'b101101;
    logic disp_rst_n, rs, ce_n, sclk, din, busy, done;

    always #4 clk = ~clk;

    disp_chain_loader #(
        .NCHIP(NCHIP), .CELLS(CELLS), .COLS(COLS), .ROWS(ROWS),
        .RST_LEN(RST_LEN), .RS_SETUP(RS_SETUP), .RS_HOLD(RS_HOLD),
        .CE_SETUP(CE_SETUP), .CLK_HI(CLK_HI), .CLK_LO(CLK_LO)
    ) i_disp_chain_loader (.*);

    int tests = 0, fails = 0, cyc = 0;
    int txn_cnt = 0, done_cnt = 0, cap_n = 0;
    int viol_w = 0, viol_ce = 0, viol_rs = 0, viol_din = 0, viol_done = 0;
    int hi_run = 0, lo_run = 0, rs_run = 0;
    logic txn_rs = 1'b0;
    logic ce_p = 1'b1, sclk_p = 1'b0, din_p = 1'b0, rs_p = 1'b0, done_p = 1'b0;
    bit cap [0:1023];
    bit exp_b [0:1023];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Monitor of the serial lines, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst) begin
            ce_p = ce_n; sclk_p = sclk; din_p = din; rs_p = rs; done_p = done;
        end else begin
            if (ce_p && !ce_n) begin
                cap_n = 0;
                if (rs_run < RS_SETUP) viol_rs++;
                if (sclk) viol_ce++;
            end
            if (!ce_p && ce_n) begin
                if (!sclk) viol_ce++;
                txn_rs = rs;
                txn_cnt++;
            end
            if (!sclk_p && sclk) begin
                if (!ce_n) begin cap[cap_n] = din; cap_n++; end
                else viol_ce++;
                if (lo_run < CLK_LO) viol_w++;
            end
            if (sclk_p && !sclk && hi_run < CLK_HI) viol_w++;
            if (sclk_p && sclk && din != din_p) viol_din++;
            if (!ce_n && rs != rs_p) viol_rs++;
            if (done && done_p) viol_done++;
            if (done) done_cnt++;
            hi_run = sclk ? hi_run + 1 : 0;
            lo_run = (!sclk && !ce_n) ? lo_run + 1 : 0;
            rs_run = (rs == rs_p) ? rs_run + 1 : 1;
            ce_p = ce_n; sclk_p = sclk; din_p = din; rs_p = rs; done_p = done;
        end
    end

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            tests++; fails++;
            $display("FAIL R11 watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    function automatic void fill_frame(input logic [FB-1:0] f);
        for (int j = 0; j < FB; j++) exp_b[j] = (j % ROWS == 0) ? 1'b0 : f[j];
    endfunction

    function automatic logic [7:0] sent_byte(input logic [7:0] w);
        return w[7] ? {1'b1, 5'b0, w[1:0]} : w;
    endfunction

    function automatic void fill_ctrl(input logic [7:0] b, input int copies);
        for (int c = 0; c < copies; c++)
            for (int k = 0; k < 8; k++) exp_b[c*8 + k] = b[7-k];
    endfunction

    task automatic check_stream(input bit rs_e, input int n_e, input string tag);
        int mism = 0;
        check(txn_rs == rs_e, {tag, " rs level"}, int'(txn_rs), int'(rs_e));
        check(cap_n == n_e, {tag, " edge count"}, cap_n, n_e);
        for (int j = 0; j < n_e; j++) if (cap[j] != exp_b[j]) mism++;
        check(mism == 0, {tag, " bit mismatches"}, mism, 0);
    endtask

    task automatic run_txn(input bit op, input logic [FB-1:0] f, input logic [7:0] cw, input bit poke);
        int k, d;
        while (busy) tick();
        k = txn_cnt; d = done_cnt;
        op_ctrl = op; frame_in = f; ctrl_in = cw; start = 1'b1;
        tick();
        start = 1'b0;
        if (poke) begin
            repeat (20) tick();
            check(busy == 1'b1, "R11 busy during write", int'(busy), 1);
            op_ctrl = ~op; ctrl_in = 8'h55; start = 1'b1;
            tick();
            start = 1'b0;
        end
        while (txn_cnt == k) tick();
        while (done_cnt == d) tick();
        check(busy == 1'b0, "R11 idle after done", int'(busy), 0);
    endtask

    initial begin
        logic [FB-1:0] f;
        logic [7:0] w;
        int n, k, d;
        void'($urandom(32'd20240611));

        repeat (4) tick();
        // R1 reset state
        check(disp_rst_n == 1'b0 && ce_n && !sclk && busy && !done, "R1 reset pins",
              int'({disp_rst_n, ce_n, sclk, busy, done}), 5'b01010);
        rst = 1'b0;
        n = 0;
        while (!disp_rst_n) begin n++; tick(); end
        check(n == RST_LEN, "R1 display reset length", n, RST_LEN);

        // R2 clear of the dot chain
        while (txn_cnt < 1) tick();
        for (int j = 0; j < FB; j++) exp_b[j] = 1'b0;
        check_stream(1'b0, FB, "R2 init dot clear");

        // R3 wake and brightness
        while (txn_cnt < 2) tick();
        fill_ctrl({2'b01, bright_in}, NCHIP);
        check_stream(1'b1, 8*NCHIP, "R3 init word 0");
        while (done_cnt < 1) tick();
        check(busy == 1'b0, "R3 idle after bring-up", int'(busy), 0);

        // R4 directed all-ones frame: row 0 must go out as zero
        f = '1;
        run_txn(1'b0, f, 8'h00, 1'b0);
        fill_frame(f);
        check_stream(1'b0, FB, "R4 all-ones frame");

        // R4 random frames
        for (int t = 0; t < 3; t++) begin
            for (int j = 0; j < FB; j++) f[j] = 1'($urandom % 2);
            run_txn(1'b0, f, 8'h00, 1'b0);
            fill_frame(f);
            check_stream(1'b0, FB, "R4 random frame");
        end

        // R11 start while busy is dropped
        for (int j = 0; j < FB; j++) f[j] = 1'($urandom % 2);
        run_txn(1'b0, f, 8'h00, 1'b1);
        fill_frame(f);
        check_stream(1'b0, FB, "R11 frame with stray start");
        k = txn_cnt; d = done_cnt;
        repeat (100) tick();
        check(txn_cnt == k, "R11 no extra transaction", txn_cnt, k);
        check(done_cnt == d, "R11 no extra done", done_cnt, d);

        // R5 word 0 control writes, serial mode
        for (int t = 0; t < 2; t++) begin
            w = {1'b0, 7'($urandom)};
            run_txn(1'b1, '0, w, 1'b0);
            fill_ctrl(w, NCHIP);
            check_stream(1'b1, 8*NCHIP, "R5 word 0 serial copies");
        end

        // R6 word 1 with reserved bits set, enabling simultaneous mode
        w = 8'hFD;
        run_txn(1'b1, '0, w, 1'b0);
        fill_ctrl(sent_byte(w), NCHIP);
        check(sent_byte(w) == 8'h81, "R6 expected word 1 image", int'(sent_byte(w)), 8'h81);
        check_stream(1'b1, 8*NCHIP, "R6 word 1 reserved bits zero");

        // R7 simultaneous mode: one copy
        w = {1'b0, 7'($urandom)};
        run_txn(1'b1, '0, w, 1'b0);
        fill_ctrl(w, 1);
        check_stream(1'b1, 8, "R7 single copy in simultaneous mode");

        w = 8'h80;
        run_txn(1'b1, '0, w, 1'b0);
        fill_ctrl(w, 1);
        check_stream(1'b1, 8, "R7 leaving simultaneous mode");

        w = {1'b0, 7'($urandom)};
        run_txn(1'b1, '0, w, 1'b0);
        fill_ctrl(w, NCHIP);
        check_stream(1'b1, 8*NCHIP, "R7 copies restored");

        // R4 frame still correct after control traffic
        for (int j = 0; j < FB; j++) f[j] = 1'($urandom % 2);
        run_txn(1'b0, f, 8'h00, 1'b0);
        fill_frame(f);
        check_stream(1'b0, FB, "R4 frame after control writes");

        repeat (10) tick();
        check(viol_rs == 0, "R8 rs setup/stability violations", viol_rs, 0);
        check(viol_ce == 0, "R9 enable/clock ordering violations", viol_ce, 0);
        check(viol_w == 0, "R10 clock width violations", viol_w, 0);
        check(viol_din == 0, "R12 data change while clock high", viol_din, 0);
        check(viol_done == 0, "R11 done wider than one cycle", viol_done, 0);
        check(done_cnt == txn_cnt - 1, "R11 one done per transaction", done_cnt, txn_cnt - 1);

        summary();
        $finish;
    end
endmodule